// File: doc/BRIEF.md
# Microsecond Event and Timestamp Timer Bank

This block supplies four 16-bit countdown event timers and one 32-bit up-counting timestamp counter. All of them are configured through one shared control word and one count word per timer, on a single-cycle register port. Writes take effect at the next clock edge. Reads are combinational and return live values. A shared tick generator divides the core clock by `CLK_PER_US` to make a 1 µs tick. Three decade stages after it make 10 µs, 100 µs and 1 ms ticks. Each timer chooses one of these timebases through its own select field.

Each event timer is a two-state machine. **HALT** holds the count. **RUN** decrements the count once per selected tick. The named transitions are:
- *start*: HALT to RUN, on a control write with the timer's enable bit set.
- *stop*: RUN to HALT, on a control write with that enable bit clear.
- *one-shot end*: RUN to HALT, when the count runs out while the periodic flag is clear.

The enable bit read back from the control word reports the state of this machine. Each expiry raises a one-cycle pulse on that timer's interrupt line. The timestamp counter counts up once per selected tick while it is enabled. It can be loaded by a write.

Top module: `usec_timer_bank`

## Requirements
- R1: After reset every register reads 0, all timers are halted and every interrupt line is low.
- R2: Register map by byte address, decoded from address bits [4:2]. 0x00 is control. 0x04, 0x08, 0x0C and 0x10 are event timers 0 to 3. 0x14 is the timestamp. Control layout: timer t timebase in bits [2t+1:2t]; timestamp timebase in [10:8]; timer t periodic flag in bit 12+t; timer t enable in bit 16+t; timestamp enable in bit 20. All other control bits read 0. Addresses 0x18 and 0x1C read 0 and ignore writes.
- R3: Writing an event timer's count word loads both its live count and its reload value from wdata[15:0]. Reading the word returns the live count.
- R4: One-shot (periodic flag 0) with value v: the count falls by one per tick. It pulses when the count reaches 0, that is v ticks after start. It then stays at 0, and its enable bit reads 0.
- R5: Periodic (flag 1) with value v: after reaching 0 the next tick reloads the last written value, so pulses are v+1 ticks apart.
- R6: Event timebase codes 0, 1, 2, 3 select 1 µs, 10 µs, 100 µs and 1 ms ticks. 1 µs equals `CLK_PER_US` clock cycles.
- R7: Clearing an enable bit freezes that counter from the next edge. Setting it again resumes from the frozen value, without reloading.
- R8: Every expiry gives a pulse exactly one cycle wide on that timer's line. Timers expiring in the same cycle all pulse in that cycle.
- R9: While enabled, the timestamp increments by one per selected tick. A write loads it. While disabled it holds. Reads return the live value.
- R10: The timestamp wraps from 0xFFFFFFFF to 0.
- R11: Timestamp timebase codes: 0 counts every clock cycle; 1, 2, 3, 4 select 1 µs, 10 µs, 100 µs and 1 ms; 5 to 7 never count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 5 | Byte address of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 4 | One-cycle expiry pulse per event timer |

## Verification
The hardest cases to reach from the ports are those where two events share one tick edge: two timers expiring together, or a stop write landing mid-count.

- For simultaneous expiry, the stimulus loads equal values into two timers and starts both with a single control write, so their countdowns are aligned to the same tick.
- For the freeze, a timer is stopped mid-count, the frozen word is read twice some time apart, and the timer is then restarted to show that the count resumes rather than reloads.
- The timestamp wrap is reached by loading a value two below the top. The tick phase within a microsecond is unknown to the bench, so one-shot delays are checked against a one-tick window. Periodic intervals are checked exactly.

// File: rtl/utimer_pkg.sv
package utimer_pkg;
    localparam int N_EVT     = 4;
    localparam int EVT_W     = 16;
    localparam int STAMP_W   = 32;
    localparam int N_DEC     = 3;
    localparam int N_RATE    = N_DEC + 2;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;
    localparam int ESEL_W    = 3;
    localparam int STB_LSB   = 8;
    localparam int PER_LSB   = 12;
    localparam int EN_LSB    = 16;
    localparam int WIDX_STMP = N_EVT + 1;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/utimer_tickgen.sv
module utimer_tickgen
    import utimer_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int DEC_RATIO  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_RATE-1:0] tick_o
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int DW = $clog2(DEC_RATIO);

    logic [PW-1:0] pre_q;
    logic [N_DEC:0] stage;

    assign stage[0] = (pre_q == PW'(CLK_PER_US - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (stage[0]) pre_q <= '0;
        else               pre_q <= pre_q + PW'(1);
    end

    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        logic [DW-1:0] dec_q;
        always_ff @(posedge clk) begin
            if (!rst_n) dec_q <= '0;
            else if (stage[d]) dec_q <= (dec_q == DW'(DEC_RATIO - 1)) ? '0 : dec_q + DW'(1);
        end
        assign stage[d+1] = stage[d] && (dec_q == DW'(DEC_RATIO - 1));
    end

    assign tick_o = {stage, 1'b1};

    if (CLK_PER_US > 1) begin : g_chk
        // R6
        us_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stage[0] |=> !stage[0]);
    end
endmodule

// File: rtl/utimer_evt_ch.sv
module utimer_evt_ch
    import utimer_pkg::*;
#(
    parameter int CNT_W = EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             per_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_en_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);
    ch_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, rel_q;
    logic irq_q;
    logic halt_req, step, at_one, at_zero, fire, os_end;

    assign halt_req = ctl_wr_i && !ctl_en_i;
    assign step     = (state_q == CH_RUN) && tick_i && !ld_i && !halt_req;
    assign at_one   = (cnt_q == CNT_W'(1));
    assign at_zero  = (cnt_q == '0);
    assign fire     = step && at_one;
    assign os_end   = step && !per_i && (at_one || at_zero) && !ctl_wr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (ctl_wr_i && ctl_en_i) state_d = CH_RUN;
            CH_RUN:  if (halt_req || os_end)   state_d = CH_HALT;
            default: state_d = CH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire;
            if (ld_i) begin
                cnt_q <= ld_val_i;
                rel_q <= ld_val_i;
            end else if (step) begin
                if (at_zero) cnt_q <= per_i ? rel_q : '0;
                else         cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign run_o = (state_q == CH_RUN);
    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R4
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> cnt_q == '0);
    // R4
    os_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !$past(per_i) && !$past(ctl_wr_i)) |-> state_q == CH_HALT);
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/utimer_stamp.sv
module utimer_stamp
    import utimer_pkg::*;
#(
    parameter int W = STAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ESEL_W-1:0] sel_i,
    input  logic [N_RATE-1:0] tick_i,
    input  logic              ld_i,
    input  logic [W-1:0]      ld_val_i,
    output logic [W-1:0]      cnt_o
);
    logic [W-1:0] cnt_q;
    logic adv;

    assign adv = en_i && (int'(sel_i) < N_RATE) && tick_i[sel_i];

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (ld_i) cnt_q <= ld_val_i;
        else if (adv)  cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;

    // R9
    stamp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sel_i == '0 && !ld_i) |=> cnt_q == $past(cnt_q) + W'(1));
    // R9
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !ld_i) |=> $stable(cnt_q));
    // R11
    stamp_dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) >= N_RATE && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/usec_timer_bank.sv
module usec_timer_bank
    import utimer_pkg::*;
#(
    parameter int CLK_PER_US = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_EVT-1:0]  irq_o
);
    logic [2:0] widx;
    logic ctl_wr;
    logic [N_RATE-1:0] ticks;
    logic [N_EVT-1:0][1:0] tb_q;
    logic [N_EVT-1:0] per_q, run;
    logic [ESEL_W-1:0] stb_q;
    logic sen_q;
    logic [N_EVT-1:0][EVT_W-1:0] evt_cnt;
    logic [STAMP_W-1:0] stamp_cnt;
    logic [DATA_W-1:0] ctrl_rd;

    assign widx   = reg_addr[4:2];
    assign ctl_wr = reg_we && (widx == 3'd0);

    utimer_tickgen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(ticks));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q  <= '0;
            per_q <= '0;
            stb_q <= '0;
            sen_q <= 1'b0;
        end else if (ctl_wr) begin
            for (int i = 0; i < N_EVT; i++) begin
                tb_q[i]  <= reg_wdata[2*i +: 2];
                per_q[i] <= reg_wdata[PER_LSB + i];
            end
            stb_q <= reg_wdata[STB_LSB +: ESEL_W];
            sen_q <= reg_wdata[EN_LSB + N_EVT];
        end
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        logic [2:0] tsel;
        logic ld;
        assign tsel = 3'(tb_q[i]) + 3'd1;
        assign ld   = reg_we && (widx == 3'(i + 1));
        utimer_evt_ch #(.CNT_W(EVT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick_i(ticks[tsel]), .per_i(per_q[i]),
            .ctl_wr_i(ctl_wr), .ctl_en_i(reg_wdata[EN_LSB + i]),
            .ld_i(ld), .ld_val_i(reg_wdata[EVT_W-1:0]),
            .run_o(run[i]), .cnt_o(evt_cnt[i]), .irq_o(irq_o[i]));
    end

    utimer_stamp #(.W(STAMP_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .en_i(sen_q), .sel_i(stb_q), .tick_i(ticks),
        .ld_i(reg_we && widx == 3'(WIDX_STMP)), .ld_val_i(reg_wdata[STAMP_W-1:0]),
        .cnt_o(stamp_cnt));

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < N_EVT; i++) begin
            ctrl_rd[2*i +: 2]    = tb_q[i];
            ctrl_rd[PER_LSB + i] = per_q[i];
            ctrl_rd[EN_LSB + i]  = run[i];
        end
        ctrl_rd[STB_LSB +: ESEL_W] = stb_q;
        ctrl_rd[EN_LSB + N_EVT]    = sen_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (widx == 3'd0)                  reg_rdata = ctrl_rd;
        else if (widx == 3'(WIDX_STMP))    reg_rdata = DATA_W'(stamp_cnt);
        else if (int'(widx) <= N_EVT)      reg_rdata = DATA_W'(evt_cnt[widx - 3'd1]);
    end

    // R8
    irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |irq_o |-> $past(|run));
endmodule

// File: tb/usec_timer_bank_test.sv
module usec_timer_bank_test;
    localparam int P  = 2;
    localparam int WD = 150000;
    localparam int NV = 4;
    // channel, load value, expected pulse spacing in cycles (code 0, periodic)
    localparam int VEC [NV][3] = '{
        '{0, 3, 8}, '{1, 1, 4}, '{2, 5, 12}, '{3, 16, 34}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0] irq_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pcnt [4];
    int last_at [4];
    int last_int [4];
    bit done = 1'b0;

    usec_timer_bank #(.CLK_PER_US(P)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial for (int i = 0; i < 4; i++) begin pcnt[i] = 0; last_at[i] = 0; last_int[i] = 0; end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (irq_o[i]) begin
                last_int[i] = cyc - last_at[i];
                last_at[i]  = cyc;
                pcnt[i]     = pcnt[i] + 1;
            end
        end
        if (cyc >= WD && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_pulses(input int ch, input int n);
        int start = pcnt[ch];
        int guard = 0;
        while (pcnt[ch] < start + n && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        logic [31:0] a, b, c;
        int p0, p1, cw;
        // R1 reset state
        repeat (3) @(negedge clk);
        rd(5'h00, a); chk("R1 ctrl", a, 0);
        rd(5'h04, a); chk("R1 cnt0", a, 0);
        rd(5'h14, a); chk("R1 stamp", a, 0);
        chk("R1 irq", 32'(irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 periodic spacing table
        for (int k = 0; k < NV; k++) begin
            wr(5'((VEC[k][0] + 1) * 4), 32'(VEC[k][1]));
            wr(5'h00, (32'd1 << (12 + VEC[k][0])) | (32'd1 << (16 + VEC[k][0])));
            wait_pulses(VEC[k][0], 3);
            chk("R5 period", 32'(last_int[VEC[k][0]]), 32'(VEC[k][2]));
            wr(5'h00, 0);
        end

        // R3 load and live readback
        wr(5'h0C, 32'h0000_1234);
        @(negedge clk); rd(5'h0C, a); chk("R3 load readback", a, 32'h1234);

        // R4 one-shot
        wr(5'h04, 4);
        p0 = pcnt[0];
        wr(5'h00, 32'h0001_0000);
        cw = cyc;
        repeat (30) @(negedge clk);
        chk("R4 single pulse", 32'(pcnt[0] - p0), 1);
        chk("R4 delay window", 32'((last_at[0] - cw >= 3 * P + 1) && (last_at[0] - cw <= 4 * P)), 1);
        rd(5'h00, a); chk("R4 enable cleared", a & 32'h0001_0000, 0);
        rd(5'h04, a); chk("R4 stays zero", a, 0);

        // R8 simultaneous expiry
        wr(5'h04, 3); wr(5'h08, 3);
        p0 = pcnt[0]; p1 = pcnt[1];
        wr(5'h00, 32'h0003_0000);
        repeat (20) @(negedge clk);
        chk("R8 both pulsed", 32'((pcnt[0] - p0) + (pcnt[1] - p1)), 2);
        chk("R8 same cycle", 32'(last_at[0]), 32'(last_at[1]));

        // R7 freeze and resume
        wr(5'h08, 100);
        wr(5'h00, 32'h0002_0000);
        repeat (10) @(negedge clk);
        wr(5'h00, 0);
        rd(5'h08, a);
        repeat (20) @(negedge clk);
        rd(5'h08, b); chk("R7 frozen", b, a);
        chk("R7 ran before stop", 32'(a < 100 && a > 80), 1);
        wr(5'h00, 32'h0002_0000);
        repeat (10) @(negedge clk);
        rd(5'h08, c); chk("R7 resumed not reloaded", 32'(c < a && c + 10 >= a), 1);
        wr(5'h00, 0);

        // R6 timebases
        wr(5'h0C, 1);
        wr(5'h00, 32'h0004_4010);
        wait_pulses(2, 3);
        chk("R6 10us code", 32'(last_int[2]), 2 * 10 * P);
        wr(5'h10, 1);
        wr(5'h00, 32'h0008_8080);
        wait_pulses(3, 3);
        chk("R6 100us code", 32'(last_int[3]), 2 * 100 * P);
        wr(5'h04, 1);
        wr(5'h00, 32'h0001_1003);
        wait_pulses(0, 3);
        chk("R6 1ms code", 32'(last_int[0]), 2 * 1000 * P);
        wr(5'h00, 0);

        // R2 control layout, reserved bits, unused addresses
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, a); chk("R2 ctrl mask", a, 32'h001F_F7FF);
        wr(5'h00, 0);
        wr(5'h18, 32'hDEAD_BEEF);
        rd(5'h18, a); chk("R2 unused 0x18", a, 0);
        rd(5'h1C, a); chk("R2 unused 0x1C", a, 0);

        // R9 / R11 timestamp every cycle
        wr(5'h14, 32'h100);
        wr(5'h00, 32'h0010_0000);
        rd(5'h14, a);
        repeat (10) @(negedge clk);
        rd(5'h14, b); chk("R11 code0 per cycle", b - a, 10);
        // R10 wrap
        wr(5'h14, 32'hFFFF_FFFE);
        rd(5'h14, a); chk("R9 stamp load", a, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        rd(5'h14, a); chk("R10 wrap", a, 1);
        // R11 1us code
        wr(5'h00, 32'h0010_0100);
        rd(5'h14, a);
        repeat (40) @(negedge clk);
        rd(5'h14, b); chk("R11 code1 per us", b - a, 20);
        // R11 dead code
        wr(5'h00, 32'h0010_0500);
        rd(5'h14, a);
        repeat (20) @(negedge clk);
        rd(5'h14, b); chk("R11 code5 holds", b, a);
        // R9 disabled holds
        wr(5'h00, 0);
        rd(5'h14, a);
        repeat (20) @(negedge clk);
        rd(5'h14, b); chk("R9 disabled holds", b, a);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule